// File: doc/BRIEF.md
# DDS Parallel Host Load Interface

This block is the parallel host port of a direct digital synthesis core. A host presents words on a data bus. The bus is 8 or 16 bits wide, and the width can be changed at run time. The host clocks each word into a 32-bit staging register with a chip select and a write strobe. Each accepted word shifts the staging register left by the current bus width, and the new word enters at the bottom. Writing to the staging register does not change any configuration or tuning register.

A separate load strobe then carries a 4-bit transfer code. A small state machine detects the rising edge of the load strobe and decodes the code. It then commits the staged word in a single clock cycle, either to the 8-bit command register or to the 32-bit frequency register 0. Any other code is discarded. The frequency word is the output frequency divided by the clock frequency, times 2^32. For example, 1 MHz from a 50 MHz clock is 0x051EB852.

The load state machine has five states:
- LS_IDLE waits for a load rising edge. On that edge it moves to LS_CMD (code 0), LS_FRQ (code 8) or LS_SKIP (any other code).
- Each of those three states lasts one cycle. It then moves to LS_HOLD if the strobe is still high, or back to LS_IDLE if it is low.
- LS_HOLD stays in place while the strobe is high and returns to LS_IDLE when it drops.

Top module: `dds_par_load`

## Requirements
- R1: After reset the command register reads 0x00 and frequency register 0 reads 0. Command value 0 means 8-bit bus, amplitude control off and synchronizer on.
- R2: A word is accepted only on a clock where the write strobe (active low) is seen rising while chip select (active low) is low. A strobe that rises while chip select is high does not enter the staging register.
- R3: With command bit 0 clear (8-bit mode), each write shifts the staging register left by 8 and places data bits [7:0] at the bottom. Data bits [15:8] are ignored. Four writes, most significant byte first, fill all 32 bits.
- R4: With command bit 0 set (16-bit mode), each write shifts the staging register left by 16 and places data bits [15:0] at the bottom. Two writes, high half first, fill all 32 bits.
- R5: Writes alone leave the command and frequency outputs unchanged.
- R6: A load rising edge with transfer code 0 copies bits [7:0] of the staging register into the command register. The outputs do not change on the clock edge that detects the load rising edge. They change on the next clock edge.
- R7: A load rising edge with transfer code 8 (binary 1000) copies all 32 staging bits into frequency register 0. The whole word changes on one clock edge, with the same timing as R6.
- R8: Any transfer code other than 0 and 8 leaves the command and frequency registers unchanged.
- R9: A change of command bit 0 takes effect from the next write. The staging register contents are kept across the change.
- R10: Holding the load strobe high commits once. A further commit needs the strobe to fall and rise again, and writes made while it is held do not reach any destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_cs_n | input | 1 | Chip select, active low |
| host_wr_n | input | 1 | Write strobe, active low; a word is taken when it rises |
| host_data | input | 16 | Host data bus; bits [7:0] only in 8-bit mode |
| xfer_load | input | 1 | Load strobe; its rising edge starts a transfer |
| xfer_code | input | 4 | Transfer code selecting the destination |
| cmd_word | output | 8 | Command register (bit 0: 16-bit bus mode) |
| freq0_word | output | 32 | Frequency register 0 |

## Verification
A table walks full 32-bit fills in both bus widths. It uses distinct byte and half-word patterns, so that an error in shift amount, lane order or lane selection changes the committed frequency word. In 8-bit mode the table puts junk on the upper data byte, which shows whether that byte is ignored. Directed cases then cover several things:
- A write with chip select high, and writes with no commit.
- Unimplemented transfer codes.
- Sampling on the clock edge that detects the load and on the edge after it, which shows the one-cycle commit latency and that the frequency word changes all at once.
- A switch of bus width right after data was staged in the other width.
- A load strobe held high during later writes, which shows that a held strobe commits only once.

// File: rtl/dds_par_pkg.sv
package dds_par_pkg;

    // Transfer codes carried by the load strobe
    localparam int unsigned CODE_W   = 4;
    localparam logic [CODE_W-1:0] XC_CMD  = 4'h0;
    localparam logic [CODE_W-1:0] XC_FRQ0 = 4'h8;

    // Command register layout
    localparam int unsigned CMD_W       = 8;
    localparam int unsigned CMD_BUS16_B = 0;

    typedef enum logic [2:0] {
        LS_IDLE = 3'd0,
        LS_CMD  = 3'd1,
        LS_FRQ  = 3'd2,
        LS_SKIP = 3'd3,
        LS_HOLD = 3'd4
    } load_state_t;

endpackage

// File: rtl/dds_wr_edge.sv
// Turns the host write strobe into a single-cycle accept pulse.
module dds_wr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_n,
    output logic wr_evt
);

    logic wr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_q <= 1'b1;
        else        wr_q <= wr_n;
    end

    always_comb wr_evt = !wr_q && wr_n && !cs_n;

    // R2
    wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |=> !wr_evt);

endmodule

// File: rtl/dds_asm_shift.sv
// Staging register: shifts left by the bus width on each accepted word.
module dds_asm_shift #(
    parameter int unsigned ASM_W    = 32,
    parameter int unsigned BUS_W    = 16,
    parameter int unsigned NARROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_evt,
    input  logic             bus16,
    input  logic [BUS_W-1:0] din,
    output logic [ASM_W-1:0] asm_q
);

    localparam int unsigned LANES      = ASM_W / NARROW_W;
    localparam int unsigned WIDE_LANES = BUS_W / NARROW_W;

    logic [ASM_W-1:0] nxt_narrow;
    logic [ASM_W-1:0] nxt_wide;

    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_lane
            if (k == 0) begin : g_n_in
                assign nxt_narrow[NARROW_W-1:0] = din[NARROW_W-1:0];
            end else begin : g_n_sh
                assign nxt_narrow[k*NARROW_W +: NARROW_W] =
                    asm_q[(k-1)*NARROW_W +: NARROW_W];
            end
            if (k < WIDE_LANES) begin : g_w_in
                assign nxt_wide[k*NARROW_W +: NARROW_W] = din[k*NARROW_W +: NARROW_W];
            end else begin : g_w_sh
                assign nxt_wide[k*NARROW_W +: NARROW_W] =
                    asm_q[(k-WIDE_LANES)*NARROW_W +: NARROW_W];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      asm_q <= '0;
        else if (wr_evt) asm_q <= bus16 ? nxt_wide : nxt_narrow;
    end

    // R3
    narrow_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt && !bus16) |=>
            (asm_q[ASM_W-1:NARROW_W] == $past(asm_q[ASM_W-NARROW_W-1:0])) &&
            (asm_q[NARROW_W-1:0] == $past(din[NARROW_W-1:0])));

    // R4
    wide_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt && bus16) |=>
            (asm_q[ASM_W-1:BUS_W] == $past(asm_q[ASM_W-BUS_W-1:0])) &&
            (asm_q[BUS_W-1:0] == $past(din)));

    // R5
    asm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_evt |=> $stable(asm_q));

endmodule

// File: rtl/dds_xfer_ctl.sv
// Load strobe state machine and destination registers.
module dds_xfer_ctl
    import dds_par_pkg::*;
#(
    parameter int unsigned ASM_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] code,
    input  logic [ASM_W-1:0]  asm_val,
    output logic [CMD_W-1:0]  cmd_q,
    output logic [ASM_W-1:0]  frq_q
);

    load_state_t state_q, state_d;
    logic load_q;
    logic load_rise;
    logic cmd_we, frq_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) load_q <= 1'b0;
        else        load_q <= load;
    end

    always_comb load_rise = load && !load_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_IDLE: begin
                if (load_rise) begin
                    if (code == XC_CMD)       state_d = LS_CMD;
                    else if (code == XC_FRQ0) state_d = LS_FRQ;
                    else                      state_d = LS_SKIP;
                end
            end
            LS_CMD, LS_FRQ, LS_SKIP: state_d = load ? LS_HOLD : LS_IDLE;
            LS_HOLD:                 state_d = load ? LS_HOLD : LS_IDLE;
            default:                 state_d = LS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        cmd_we = 1'b0;
        frq_we = 1'b0;
        unique case (state_q)
            LS_CMD:  cmd_we = 1'b1;
            LS_FRQ:  frq_we = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
            frq_q <= '0;
        end else begin
            if (cmd_we) cmd_q <= asm_val[CMD_W-1:0];
            if (frq_we) frq_q <= asm_val;
        end
    end

    // R6
    cmd_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |=> (cmd_q == $past(asm_val[CMD_W-1:0])) && $stable(frq_q));

    // R7
    frq_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frq_we |=> (frq_q == $past(asm_val)) && $stable(cmd_q));

    // R8
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_IDLE && load_rise && code != XC_CMD && code != XC_FRQ0)
            |=> ##1 ($stable(cmd_q) && $stable(frq_q)));

    // R10
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_HOLD) |=> ($stable(cmd_q) && $stable(frq_q)));

    // R7
    one_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_we, frq_we}));

endmodule

// File: rtl/dds_par_load.sv
module dds_par_load
    import dds_par_pkg::*;
#(
    parameter int unsigned ASM_W    = 32,
    parameter int unsigned BUS_W    = 16,
    parameter int unsigned NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs_n,
    input  logic              host_wr_n,
    input  logic [BUS_W-1:0]  host_data,
    input  logic              xfer_load,
    input  logic [CODE_W-1:0] xfer_code,
    output logic [CMD_W-1:0]  cmd_word,
    output logic [ASM_W-1:0]  freq0_word
);

    logic             wr_evt;
    logic [ASM_W-1:0] asm_q;
    logic             bus16;

    always_comb bus16 = cmd_word[CMD_BUS16_B];

    dds_wr_edge u_wr (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (host_cs_n),
        .wr_n   (host_wr_n),
        .wr_evt (wr_evt)
    );

    dds_asm_shift #(
        .ASM_W    (ASM_W),
        .BUS_W    (BUS_W),
        .NARROW_W (NARROW_W)
    ) u_asm (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_evt (wr_evt),
        .bus16  (bus16),
        .din    (host_data),
        .asm_q  (asm_q)
    );

    dds_xfer_ctl #(
        .ASM_W (ASM_W)
    ) u_xfer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (xfer_load),
        .code    (xfer_code),
        .asm_val (asm_q),
        .cmd_q   (cmd_word),
        .frq_q   (freq0_word)
    );

    // R5
    write_no_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_load && $past(!xfer_load)) |=> ($stable(cmd_word) && $stable(freq0_word)));

endmodule

// File: tb/tb_dds_par_load.sv
module tb_dds_par_load;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cs_n = 1'b1;
    logic        host_wr_n = 1'b1;
    logic [15:0] host_data = '0;
    logic        xfer_load = 1'b0;
    logic [3:0]  xfer_code = '0;
    logic [7:0]  cmd_word;
    logic [31:0] freq0_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit m16 = 1'b0;

    always #10 clk = ~clk;

    dds_par_load dut (
        .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_wr_n(host_wr_n),
        .host_data(host_data), .xfer_load(xfer_load), .xfer_code(xfer_code),
        .cmd_word(cmd_word), .freq0_word(freq0_word)
    );

    // {m16, w0, w1, w2, w3, expected frequency word}
    localparam logic [96:0] VEC [0:4] = '{
        {1'b0, 16'hC312, 16'hC334, 16'hC356, 16'hC378, 32'h12345678},
        {1'b0, 16'h7705, 16'h771E, 16'h77B8, 16'h7752, 32'h051EB852},
        {1'b1, 16'h051E, 16'hB852, 16'h0000, 16'h0000, 32'h051EB852},
        {1'b1, 16'hDEAD, 16'hBEEF, 16'h0000, 16'h0000, 32'hDEADBEEF},
        {1'b0, 16'hFFFF, 16'h0000, 16'h00FF, 16'hA501, 32'hFF00FF01}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [15:0] d, input bit cs);
        @(negedge clk);
        host_cs_n = !cs; host_data = d; host_wr_n = 1'b0;
        @(negedge clk);
        host_wr_n = 1'b1;
        @(negedge clk);
        host_cs_n = 1'b1;
    endtask

    task automatic do_load(input logic [3:0] c);
        @(negedge clk);
        xfer_load = 1'b1; xfer_code = c;
        @(negedge clk);
        @(negedge clk);
        xfer_load = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_mode(input bit want16);
        if (want16 != m16) begin
            host_write(want16 ? 16'h0001 : 16'h0000, 1'b1);
            do_load(4'h0);
            check("R6 mode cmd", {24'h0, cmd_word}, {31'h0, want16});
            m16 = want16;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] prev;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 cmd reset", {24'h0, cmd_word}, 32'h0);
        check("R1 freq reset", freq0_word, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4 R7 table walk
        for (int i = 0; i < 5; i++) begin
            set_mode(VEC[i][96]);
            for (int j = 0; j < (VEC[i][96] ? 2 : 4); j++)
                host_write(VEC[i][95-16*j -: 16], 1'b1);
            do_load(4'h8);
            check(VEC[i][96] ? "R4 R7 wide fill" : "R3 R7 narrow fill",
                  freq0_word, VEC[i][31:0]);
        end

        // R5 writes alone: freq stays 0xFF00FF01, cmd 0
        host_write(16'h0011, 1'b1);
        host_write(16'h0022, 1'b1);
        host_write(16'h0033, 1'b1);
        host_write(16'h0044, 1'b1);
        repeat (3) @(negedge clk);
        check("R5 freq untouched", freq0_word, 32'hFF00FF01);
        check("R5 cmd untouched", {24'h0, cmd_word}, 32'h0);

        // R2 write with chip select high is ignored
        host_write(16'h0099, 1'b0);
        do_load(4'h8);
        check("R2 cs high ignored", freq0_word, 32'h11223344);

        // R8 unimplemented codes
        host_write(16'h00AB, 1'b1);
        foreach (VEC[i]) begin end
        do_load(4'h3);
        do_load(4'h1);
        do_load(4'h9);
        do_load(4'hF);
        check("R8 freq unchanged", freq0_word, 32'h11223344);
        check("R8 cmd unchanged", {24'h0, cmd_word}, 32'h0);

        // R6 R7 latency and atomic update
        host_write(16'h00CD, 1'b1);
        @(negedge clk);
        xfer_load = 1'b1; xfer_code = 4'h8;
        @(negedge clk);
        check("R7 no change on detect edge", freq0_word, 32'h11223344);
        @(negedge clk);
        check("R7 whole word next edge", freq0_word, 32'h3344ABCD);
        xfer_load = 1'b0;
        @(negedge clk);

        // R9 runtime width switch keeps staged data
        host_write(16'h0000, 1'b1);
        host_write(16'h0000, 1'b1);
        host_write(16'h0000, 1'b1);
        host_write(16'h0001, 1'b1);
        do_load(4'h0);
        check("R6 cmd from low byte", {24'h0, cmd_word}, 32'h1);
        m16 = 1'b1;
        host_write(16'hBEEF, 1'b1);
        do_load(4'h8);
        check("R9 first wide write", freq0_word, 32'h0001BEEF);

        // R10 held strobe commits once
        host_write(16'h1357, 1'b1);
        @(negedge clk);
        xfer_load = 1'b1; xfer_code = 4'h8;
        repeat (2) @(negedge clk);
        prev = freq0_word;
        check("R10 first commit", prev, 32'hBEEF1357);
        host_write(16'h2468, 1'b1);
        repeat (4) @(negedge clk);
        check("R10 held no recommit", freq0_word, 32'hBEEF1357);
        xfer_load = 1'b0;
        @(negedge clk);
        do_load(4'h8);
        check("R10 recommit after release", freq0_word, 32'h13572468);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule